// File: doc/BRIEF.md
# Dual-Port Interleaving DAC Input Multiplexer

This block feeds a converter's output latch from two parallel data ports. It runs from a single clock at the output update rate. It works out internally which clock edges load the input latches, so no second clock is needed. Each port has its own input latch, and the output latch takes its word from one of them on every edge.

A 2-bit mode code picks the behaviour. Code 00 interleaves the two ports. Both ports load on the same edge. On that edge the port-2 word loaded one capture earlier goes out. On the following edge the port-1 word goes out. Each port therefore runs at half the output rate.

Codes 01 and 10 pass a single port, port 1 or port 2, at the full rate. Code 11 is illegal. It freezes the output and raises an error flag.

A mode change is taken only on an edge that captures. Entering interleaved operation always starts on a capture edge.

Top module: `dual_port_dac_mux`

## Requirements
- R1: Reset is synchronous and active high. It clears both input latches, the output word, the capture strobe and the error flag to zero. The first clock edge after reset is a capture edge.
- R2: In mode code 00, a capture edge has three effects. Both input latches load their port data. The output word becomes the port-2 latch value held before that edge. The capture strobe is high in the following cycle.
- R3: In mode code 00, the edge after a capture edge has these effects. The output word becomes the port-1 latch value. Neither latch loads, so port data presented for this edge never reaches the output. The capture strobe is low in the following cycle.
- R4: While mode code 00 is held, capture edges and port-1 output edges alternate strictly. Each port is therefore sampled at half the output update rate.
- R5: In mode code 01, every edge loads the port-1 latch. The output word takes the port-1 latch value held before that edge, so port-1 data appears one edge after its capture. The strobe is high every cycle.
- R6: In mode code 10, every edge loads the port-2 latch. The output word takes the port-2 latch value held before that edge. The strobe is high every cycle.
- R7: In a single-port mode the unselected input latch keeps its value. It reappears unchanged at the output after a later switch to that port.
- R8: Mode code 11 is illegal. On such a capture edge the error flag goes high, the output word stays at its last value, neither latch loads, and the strobe goes low.
- R9: The first capture edge that sees a legal mode code clears the error flag and resumes normal operation from the held latch contents.
- R10: A mode change presented on the port-1 output edge of interleaved mode is not acted on until the next edge, which is always a capture edge.
- R11: Switching from a single-port mode into code 00 makes the switching edge a capture edge. The port-1 output edge follows it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock at the output update rate |
| rst | input | 1 | Synchronous reset, active high |
| mode_sel | input | 2 | 00 interleave, 01 port 1 only, 10 port 2 only, 11 illegal |
| port1_data | input | DATA_W | Port 1 input word |
| port2_data | input | DATA_W | Port 2 input word |
| dac_word | output | DATA_W | Output latch word |
| capture_strobe | output | 1 | High in the cycle after an edge that loaded an input latch |
| mode_error | output | 1 | High while the last capture edge saw code 11 |

## Verification
The hardest situation to reach is a mode change that lands on the port-1 output edge of interleaved mode. The change must wait one edge there. Reaching it needs a stimulus that counts edges from reset, so that the new code is presented exactly on the non-capture slot.

The realign test does this. It enters interleaved mode and captures once, then presents code 01 on the next edge and observes that the edge still outputs port 1 without loading. It then returns to code 00 from the single-port mode to show that the switching edge captures.

The illegal-code test enters code 11 from a known output word. It then changes both port inputs and confirms that neither latch moved once a legal code returns.

// File: rtl/dpm_pkg.sv
package dpm_pkg;

    typedef enum logic [1:0] {
        MODE_ILV = 2'b00,
        MODE_P1  = 2'b01,
        MODE_P2  = 2'b10,
        MODE_BAD = 2'b11
    } mode_e;

    typedef enum logic [1:0] {
        OSEL_HOLD = 2'b00,
        OSEL_A    = 2'b01,
        OSEL_B    = 2'b10
    } osel_e;

    typedef struct packed {
        logic slot_pending;
        logic err;
        logic strobe;
    } ctl_state_t;

endpackage

// File: rtl/dpm_phase_ctrl.sv
module dpm_phase_ctrl
    import dpm_pkg::*;
#(
    parameter int NUM_PORTS = 2
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [1:0]           mode_sel,
    output logic                 cap,
    output logic [NUM_PORTS-1:0] load,
    output osel_e                osel,
    output logic                 strobe_q,
    output logic                 err_q
);

    ctl_state_t st_d, st_q;
    mode_e      mode_now;

    always_comb begin
        mode_now = mode_e'(mode_sel);
        st_d     = st_q;
        load     = '0;
        osel     = OSEL_HOLD;
        cap      = !st_q.slot_pending;
        if (cap) begin
            unique case (mode_now)
                MODE_ILV: begin
                    load             = '1;
                    osel             = OSEL_B;
                    st_d.slot_pending = 1'b1;
                end
                MODE_P1: begin
                    load[0] = 1'b1;
                    osel    = OSEL_A;
                end
                MODE_P2: begin
                    load[1] = 1'b1;
                    osel    = OSEL_B;
                end
                default: begin
                    osel = OSEL_HOLD;
                end
            endcase
            st_d.err = (mode_now == MODE_BAD);
        end else begin
            osel              = OSEL_A;
            st_d.slot_pending = 1'b0;
        end
        st_d.strobe = |load;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign strobe_q = st_q.strobe;
    assign err_q    = st_q.err;

endmodule

// File: rtl/dpm_port_latch.sv
module dpm_port_latch #(
    parameter int W = 12
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] din,
    output logic [W-1:0] q
);

    logic [W-1:0] word_d, word_q;

    always_comb begin
        word_d = word_q;
        if (load) begin
            word_d = din;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            word_q <= '0;
        end else begin
            word_q <= word_d;
        end
    end

    assign q = word_q;

endmodule

// File: rtl/dpm_out_latch.sv
module dpm_out_latch
    import dpm_pkg::*;
#(
    parameter int W = 12
) (
    input  logic         clk,
    input  logic         rst,
    input  osel_e        osel,
    input  logic [W-1:0] held_a,
    input  logic [W-1:0] held_b,
    output logic [W-1:0] q
);

    logic [W-1:0] out_d, out_q;

    always_comb begin
        out_d = out_q;
        unique case (osel)
            OSEL_A:  out_d = held_a;
            OSEL_B:  out_d = held_b;
            default: out_d = out_q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    assign q = out_q;

endmodule

// File: rtl/dual_port_dac_mux.sv
module dual_port_dac_mux
    import dpm_pkg::*;
#(
    parameter int DATA_W = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [1:0]        mode_sel,
    input  logic [DATA_W-1:0] port1_data,
    input  logic [DATA_W-1:0] port2_data,
    output logic [DATA_W-1:0] dac_word,
    output logic              capture_strobe,
    output logic              mode_error
);

    localparam int NUM_PORTS = 2;

    logic                 cap;
    logic [NUM_PORTS-1:0] load;
    osel_e                osel;
    logic [DATA_W-1:0]    port_in [NUM_PORTS];
    logic [DATA_W-1:0]    held    [NUM_PORTS];
    logic [DATA_W-1:0]    held_a, held_b;

    assign port_in[0] = port1_data;
    assign port_in[1] = port2_data;

    dpm_phase_ctrl #(.NUM_PORTS(NUM_PORTS)) u_ctl (
        .clk      (clk),
        .rst      (rst),
        .mode_sel (mode_sel),
        .cap      (cap),
        .load     (load),
        .osel     (osel),
        .strobe_q (capture_strobe),
        .err_q    (mode_error)
    );

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
        dpm_port_latch #(.W(DATA_W)) u_lat (
            .clk  (clk),
            .rst  (rst),
            .load (load[p]),
            .din  (port_in[p]),
            .q    (held[p])
        );
    end

    assign held_a = held[0];
    assign held_b = held[1];

    dpm_out_latch #(.W(DATA_W)) u_out (
        .clk    (clk),
        .rst    (rst),
        .osel   (osel),
        .held_a (held_a),
        .held_b (held_b),
        .q      (dac_word)
    );

endmodule

// File: rtl/dpm_checker.sv
module dpm_checker #(
    parameter int W = 12
) (
    input logic         clk,
    input logic         rst,
    input logic [1:0]   mode_sel,
    input logic [W-1:0] port1_data,
    input logic [W-1:0] port2_data,
    input logic [W-1:0] dac_word,
    input logic         capture_strobe,
    input logic         mode_error,
    input logic         cap,
    input logic [W-1:0] held_a,
    input logic [W-1:0] held_b
);

    p_ilv_cap_r2: assert property (@(posedge clk) disable iff (rst)
        (cap && mode_sel == 2'b00) |=>
            (dac_word == $past(held_b)) && capture_strobe && (held_a == $past(port1_data)));

    p_ilv_slot_r3: assert property (@(posedge clk) disable iff (rst)
        (!cap) |=> (dac_word == $past(held_a)) && !capture_strobe
                   && $stable(held_a) && $stable(held_b));

    p_alternate_r4: assert property (@(posedge clk) disable iff (rst)
        (cap && mode_sel == 2'b00) |=> !cap);

    p_single_a_r5: assert property (@(posedge clk) disable iff (rst)
        (cap && mode_sel == 2'b01) |=>
            (dac_word == $past(held_a)) && (held_a == $past(port1_data)) && capture_strobe && cap);

    p_single_b_r6: assert property (@(posedge clk) disable iff (rst)
        (cap && mode_sel == 2'b10) |=>
            (dac_word == $past(held_b)) && (held_b == $past(port2_data)) && capture_strobe && cap);

    p_unsel_hold_r7: assert property (@(posedge clk) disable iff (rst)
        (cap && (mode_sel == 2'b01)) |=> $stable(held_b));

    p_bad_freeze_r8: assert property (@(posedge clk) disable iff (rst)
        (cap && mode_sel == 2'b11) |=>
            mode_error && $stable(dac_word) && !capture_strobe
            && $stable(held_a) && $stable(held_b));

    p_err_clear_r9: assert property (@(posedge clk) disable iff (rst)
        (cap && mode_sel != 2'b11) |=> !mode_error);

    p_slot_then_cap_r10: assert property (@(posedge clk) disable iff (rst)
        (!cap) |=> cap);

endmodule

bind dual_port_dac_mux dpm_checker #(.W(DATA_W)) u_chk (
    .clk            (clk),
    .rst            (rst),
    .mode_sel       (mode_sel),
    .port1_data     (port1_data),
    .port2_data     (port2_data),
    .dac_word       (dac_word),
    .capture_strobe (capture_strobe),
    .mode_error     (mode_error),
    .cap            (cap),
    .held_a         (held_a),
    .held_b         (held_b)
);

// File: tb/dual_port_dac_mux_bench.sv
module dual_port_dac_mux_bench;

    localparam int W = 12;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [1:0]   mode_sel = 2'b00;
    logic [W-1:0] port1_data = '0;
    logic [W-1:0] port2_data = '0;
    logic [W-1:0] dac_word;
    logic         capture_strobe;
    logic         mode_error;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #2 clk = ~clk;

    dual_port_dac_mux #(.DATA_W(W)) u_dual_port_dac_mux (
        .clk            (clk),
        .rst            (rst),
        .mode_sel       (mode_sel),
        .port1_data     (port1_data),
        .port2_data     (port2_data),
        .dac_word       (dac_word),
        .capture_strobe (capture_strobe),
        .mode_error     (mode_error)
    );

    task automatic check(input string req, input int actual, input int expected);
        n_checks++;
        if (actual != expected) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, actual, expected);
        end
    endtask

    task automatic do_reset();
        rst = 1'b1;
        repeat (2) @(posedge clk);
        #1;
        check("R1 word", dac_word, 0);
        check("R1 strobe", capture_strobe, 0);
        check("R1 error", mode_error, 0);
        rst = 1'b0;
    endtask

    // drive one edge's inputs, then sample after the edge
    task automatic step(input string req, input logic [1:0] m, input int a, input int b,
                        input int exp_w, input int exp_s, input int exp_e);
        mode_sel   = m;
        port1_data = W'(a);
        port2_data = W'(b);
        @(posedge clk);
        #1;
        check({req, " word"}, dac_word, exp_w);
        check({req, " strobe"}, capture_strobe, exp_s);
        check({req, " error"}, mode_error, exp_e);
    endtask

    task automatic t_interleave();
        do_reset();
        step("R1 R2 first capture", 2'b00, 'h111, 'h222, 'h000, 1, 0);
        step("R3 port1 slot",       2'b00, 'hAAA, 'hBBB, 'h111, 0, 0);
        step("R2 capture",          2'b00, 'h333, 'h444, 'h222, 1, 0);
        step("R3 R4 port1 slot",    2'b00, 'hCCC, 'hDDD, 'h333, 0, 0);
        step("R2 R4 capture",       2'b00, 'h555, 'h666, 'h444, 1, 0);
        step("R3 slot",             2'b00, 'h000, 'h000, 'h555, 0, 0);
    endtask

    task automatic t_single();
        do_reset();
        step("R5 first",            2'b01, 'h101, 'hF01, 'h000, 1, 0);
        step("R5 delay",            2'b01, 'h102, 'hF02, 'h101, 1, 0);
        step("R5 delay",            2'b01, 'h103, 'hF03, 'h102, 1, 0);
        step("R6 R7 port2 held",    2'b10, 'h7F0, 'h201, 'h000, 1, 0);
        step("R6 delay",            2'b10, 'h7F1, 'h202, 'h201, 1, 0);
        step("R6 delay",            2'b10, 'h7F2, 'h203, 'h202, 1, 0);
        step("R7 port1 held",       2'b01, 'h104, 'h000, 'h103, 1, 0);
    endtask

    task automatic t_illegal();
        do_reset();
        step("R6 setup",            2'b10, 'h000, 'h3A1, 'h000, 1, 0);
        step("R6 setup",            2'b10, 'h000, 'h3A2, 'h3A1, 1, 0);
        step("R8 freeze",           2'b11, 'hFFF, 'hFFF, 'h3A1, 0, 1);
        step("R8 freeze",           2'b11, 'hEEE, 'hEEE, 'h3A1, 0, 1);
        step("R9 resume held",      2'b10, 'h000, 'h3A3, 'h3A2, 1, 0);
        step("R9 continue",         2'b10, 'h000, 'h000, 'h3A3, 1, 0);
    endtask

    task automatic t_realign();
        do_reset();
        step("R2 capture",          2'b00, 'h511, 'h522, 'h000, 1, 0);
        step("R10 change waits",    2'b01, 'h5F0, 'h5F1, 'h511, 0, 0);
        step("R10 change applies",  2'b01, 'h512, 'h5F2, 'h511, 1, 0);
        step("R5 after change",     2'b01, 'h513, 'h5F3, 'h512, 1, 0);
        step("R11 switch captures", 2'b00, 'h531, 'h532, 'h522, 1, 0);
        step("R11 port1 slot",      2'b00, 'h5E0, 'h5E1, 'h531, 0, 0);
        step("R11 next capture",    2'b00, 'h000, 'h000, 'h532, 1, 0);
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    initial begin
        t_interleave();
        t_single();
        t_illegal();
        t_realign();
        done = 1'b1;
        finish_run();
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            finish_run();
        end
    end

endmodule